// File: doc/BRIEF.md
# Asynchronous Serial Channel with Diagnostic Loopback

This block is a single asynchronous serial channel. It has a transmit engine that frames host bytes onto a serial line, a receive engine that oversamples its line at sixteen times the bit rate, and a small receive queue that the host drains one byte at a time. Character length (5 to 8 bits), parity (none, even or odd) and one or two stop bits come from static configuration inputs. The transmit and receive bit rates have separate divisors.

Two mode bits add two diagnostic paths. The first is an internal loop. The transmit stream feeds the receive engine directly, the outgoing pin rests at the idle level, and the incoming pin is ignored. The second is an echo mode. Every character that arrives complete on the incoming pin is sent back out through the transmitter, framed with the current format settings. Echoed characters are never queued for the host. A one-character echo holding register sits between the two engines. A character that completes while that register is still full is dropped and raises an overrun flag.

Mode changes are deferred until both engines are idle and no echo is pending, so that no frame is cut in half. Error flags are sticky until the host pulses a clear.

Top module: `uart_lb_ctrl`

## Requirements
- R1: After reset, txd is 1, tx_busy is 0, rx_avail is 0, and par_err, frm_err and ovr_err are all 0.
- R2: In normal mode, a byte written while tx_busy is 0 leaves on txd in this order: one low start bit, the data bits LSB first (count = 5 + data_bits), a parity bit when parity_en is 1, then one stop bit, or two when stop_two is 1, at level 1. Each bit lasts 16*(tx_div+1) clocks. The parity bit is the XOR of the sent data bits, inverted when parity_odd is 1.
- R3: In normal mode, a frame arriving on rxd is queued and presented on rd_data with rx_avail = 1. Its data bits are right-aligned and the upper bits are zero. A pulse on rd_en removes the head entry.
- R4: A low pulse on the receive line that does not last to the middle of the start bit (8 sample ticks) starts no character.
- R5: A received parity mismatch sets par_err, and a stop bit sampled at 0 sets frm_err. Both flags stay at 1 through later good characters until clr_status is pulsed.
- R6: With loop_sel = 2'b10 (bit 1 = internal loop), a host-written byte goes through the receive engine into the queue with the configured format, and txd stays at 1 throughout.
- R7: In the internal loop, activity on rxd puts nothing into the queue and sets no flag.
- R8: With loop_sel = 2'b11, the internal loop is used and the echo path is not.
- R9: A new loop_sel value takes effect only when both engines are idle and the echo register is empty. A frame already being sent finishes on txd.
- R10: With loop_sel = 2'b01 (bit 0 = echo), each character received on rxd is sent back on txd only after its stop bit has been sampled. The echo uses the current parity and stop settings.
- R11: In echo mode, received characters never enter the queue, and host writes are ignored.
- R12: In echo mode, a character that completes while the single echo register is still occupied is discarded and sets ovr_err (sticky until clr_status).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| loop_sel | input | 2 | Bit 1: internal loop; bit 0: echo; bit 1 wins |
| data_bits | input | 2 | Character length minus 5 |
| parity_en | input | 1 | Add or check a parity bit |
| parity_odd | input | 1 | Odd parity when 1, even when 0 |
| stop_two | input | 1 | Two stop bits on transmit |
| tx_div | input | 16 | Transmit sample tick every tx_div+1 clocks |
| rx_div | input | 16 | Receive sample tick every rx_div+1 clocks |
| wr_en | input | 1 | Host write strobe |
| wr_data | input | 8 | Host byte to send |
| tx_busy | output | 1 | Transmit engine is sending a frame |
| rd_en | input | 1 | Remove the head of the receive queue |
| rd_data | output | 8 | Head of the receive queue |
| rx_avail | output | 1 | Receive queue is not empty |
| clr_status | input | 1 | Clear all sticky error flags |
| par_err | output | 1 | Sticky parity error |
| frm_err | output | 1 | Sticky framing error |
| ovr_err | output | 1 | Sticky overrun |
| txd | output | 1 | Serial output, idle 1 |
| rxd | input | 1 | Serial input, idle 1 |

## Verification
On every cycle the assertions check four things. The active mode never changes while an engine is busy. The error flags never drop without a clear. The receive queue stays empty for the whole time echo mode is active. A completion that meets a full echo register always produces an overrun. Bit ordering, parity values, the moment the echo starts, the rejection of short glitches, and which characters survive an overrun can only be shown by the bench's scenarios. The bench drives real frames and decodes txd bit by bit for these.

// File: rtl/uart_lb_pkg.sv
package uart_lb_pkg;

    typedef enum logic [1:0] {
        LB_NORMAL = 2'd0,
        LB_LOCAL  = 2'd1,
        LB_REMOTE = 2'd2
    } lb_mode_e;

    typedef struct packed {
        logic [1:0] len_code;
        logic       par_en;
        logic       par_odd;
        logic       stop_two;
    } frame_cfg_t;

    function automatic logic [3:0] char_len(input logic [1:0] code);
        return 4'd5 + {2'b00, code};
    endfunction

    function automatic logic calc_parity(input logic [7:0] d, input logic [1:0] code,
                                         input logic odd);
        logic [7:0] mask;
        mask = 8'hFF >> (2'd3 - code);
        return (^(d & mask)) ^ odd;
    endfunction

endpackage

// File: rtl/uart_lb_fifo.sv
module uart_lb_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic         full,
    output logic         empty
);
    localparam int AW = $clog2(DEPTH);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [AW:0]             wp;
        logic [AW:0]             rp;
    } fifo_st_t;

    fifo_st_t r_q, r_d;

    assign empty = (r_q.wp == r_q.rp);
    assign full  = (r_q.wp[AW-1:0] == r_q.rp[AW-1:0]) && (r_q.wp[AW] != r_q.rp[AW]);
    assign head  = r_q.mem[r_q.rp[AW-1:0]];

    always_comb begin
        r_d = r_q;
        if (push && !full) begin
            r_d.mem[r_q.wp[AW-1:0]] = din;
            r_d.wp = r_q.wp + 1'b1;
        end
        if (pop && !empty) begin
            r_d.rp = r_q.rp + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    // R3: occupancy never exceeds the queue depth
    a_r3_fifo_bound: assert property (@(posedge clk) disable iff (!rst_n)
        ((r_q.wp - r_q.rp) <= (AW+1)'(DEPTH)));

endmodule

// File: rtl/uart_lb_tx.sv
module uart_lb_tx
    import uart_lb_pkg::*;
#(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div,
    input  frame_cfg_t       cfg,
    input  logic             load,
    input  logic [7:0]       load_data,
    output logic             busy,
    output logic             line
);
    typedef enum logic [2:0] {T_IDLE, T_START, T_DATA, T_PAR, T_STOP} tx_st_e;

    typedef struct packed {
        tx_st_e           st;
        logic [DIV_W-1:0] pre;
        logic [3:0]       sub;
        logic [2:0]       idx;
        logic [7:0]       sh;
        logic             pbit;
        logic             extra_stop;
    } tx_reg_t;

    tx_reg_t r_q, r_d;
    logic    tick;

    assign tick = (r_q.pre == div);
    assign busy = (r_q.st != T_IDLE);

    always_comb begin
        case (r_q.st)
            T_START: line = 1'b0;
            T_DATA:  line = r_q.sh[0];
            T_PAR:   line = r_q.pbit;
            default: line = 1'b1;
        endcase
    end

    always_comb begin
        r_d = r_q;
        if (r_q.st != T_IDLE) r_d.pre = tick ? '0 : r_q.pre + 1'b1;
        if (r_q.st == T_IDLE) begin
            if (load) begin
                r_d.st         = T_START;
                r_d.pre        = '0;
                r_d.sub        = '0;
                r_d.idx        = '0;
                r_d.sh         = load_data;
                r_d.pbit       = calc_parity(load_data, cfg.len_code, cfg.par_odd);
                r_d.extra_stop = cfg.stop_two;
            end
        end else if (tick) begin
            r_d.sub = r_q.sub + 4'd1;
            if (r_q.sub == 4'd15) begin
                case (r_q.st)
                    T_START: r_d.st = T_DATA;
                    T_DATA: begin
                        r_d.sh  = r_q.sh >> 1;
                        r_d.idx = r_q.idx + 3'd1;
                        if ({1'b0, r_q.idx} == char_len(cfg.len_code) - 4'd1)
                            r_d.st = cfg.par_en ? T_PAR : T_STOP;
                    end
                    T_PAR: r_d.st = T_STOP;
                    default: begin
                        if (r_q.extra_stop) r_d.extra_stop = 1'b0;
                        else                r_d.st = T_IDLE;
                    end
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{st: T_IDLE, default: '0};
        else        r_q <= r_d;
    end

    // R2: an accepted load is followed by the low start bit
    a_r2_start_low: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !busy) |=> (line == 1'b0));

endmodule

// File: rtl/uart_lb_rx.sv
module uart_lb_rx
    import uart_lb_pkg::*;
#(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div,
    input  frame_cfg_t       cfg,
    input  logic             line,
    output logic             busy,
    output logic             done,
    output logic [7:0]       data,
    output logic             perr,
    output logic             ferr
);
    typedef enum logic [2:0] {R_IDLE, R_START, R_DATA, R_PAR, R_STOP} rx_st_e;

    typedef struct packed {
        rx_st_e           st;
        logic [DIV_W-1:0] pre;
        logic [3:0]       sub;
        logic [2:0]       idx;
        logic [7:0]       sh;
        logic             pbad;
        logic             done;
        logic             perr;
        logic             ferr;
    } rx_reg_t;

    rx_reg_t r_q, r_d;
    logic    tick;

    assign tick = (r_q.pre == div);
    assign busy = (r_q.st != R_IDLE);
    assign done = r_q.done;
    assign data = r_q.sh;
    assign perr = r_q.perr;
    assign ferr = r_q.ferr;

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        if (r_q.st != R_IDLE) r_d.pre = tick ? '0 : r_q.pre + 1'b1;
        case (r_q.st)
            R_IDLE: begin
                if (!line) begin
                    r_d.st  = R_START;
                    r_d.pre = '0;
                    r_d.sub = '0;
                end
            end
            R_START: begin
                if (tick) begin
                    r_d.sub = r_q.sub + 4'd1;
                    if (r_q.sub == 4'd7) begin
                        if (!line) begin
                            r_d.st   = R_DATA;
                            r_d.sub  = '0;
                            r_d.idx  = '0;
                            r_d.sh   = '0;
                            r_d.pbad = 1'b0;
                        end else begin
                            r_d.st = R_IDLE;
                        end
                    end
                end
            end
            R_DATA: begin
                if (tick) begin
                    r_d.sub = r_q.sub + 4'd1;
                    if (r_q.sub == 4'd15) begin
                        r_d.sh[r_q.idx] = line;
                        r_d.idx = r_q.idx + 3'd1;
                        if ({1'b0, r_q.idx} == char_len(cfg.len_code) - 4'd1)
                            r_d.st = cfg.par_en ? R_PAR : R_STOP;
                    end
                end
            end
            R_PAR: begin
                if (tick) begin
                    r_d.sub = r_q.sub + 4'd1;
                    if (r_q.sub == 4'd15) begin
                        r_d.pbad = (line != calc_parity(r_q.sh, cfg.len_code, cfg.par_odd));
                        r_d.st   = R_STOP;
                    end
                end
            end
            default: begin
                if (tick) begin
                    r_d.sub = r_q.sub + 4'd1;
                    if (r_q.sub == 4'd15) begin
                        r_d.done = 1'b1;
                        r_d.perr = cfg.par_en & r_q.pbad;
                        r_d.ferr = !line;
                        r_d.st   = R_IDLE;
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{st: R_IDLE, default: '0};
        else        r_q <= r_d;
    end

    // R3: each assembled character is reported by a single-cycle pulse
    a_r3_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

endmodule

// File: rtl/uart_lb_ctrl.sv
module uart_lb_ctrl
    import uart_lb_pkg::*;
#(
    parameter int DIV_W      = 16,
    parameter int FIFO_DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       loop_sel,
    input  logic [1:0]       data_bits,
    input  logic             parity_en,
    input  logic             parity_odd,
    input  logic             stop_two,
    input  logic [DIV_W-1:0] tx_div,
    input  logic [DIV_W-1:0] rx_div,
    input  logic             wr_en,
    input  logic [7:0]       wr_data,
    output logic             tx_busy,
    input  logic             rd_en,
    output logic [7:0]       rd_data,
    output logic             rx_avail,
    input  logic             clr_status,
    output logic             par_err,
    output logic             frm_err,
    output logic             ovr_err,
    output logic             txd,
    input  logic             rxd
);
    typedef struct packed {
        lb_mode_e   mode;
        logic       echo_full;
        logic [7:0] echo_data;
        logic       perr;
        logic       ferr;
        logic       oerr;
        logic       rx_s1;
        logic       rx_s2;
    } ctrl_reg_t;

    ctrl_reg_t  r_q, r_d;
    frame_cfg_t cfg;
    lb_mode_e   want;
    logic       tx_line, tx_busy_w, tx_load, rx_busy_w, rx_done, rx_perr, rx_ferr;
    logic       rx_line, fifo_push, fifo_full, fifo_empty, echo_take;
    logic [7:0] tx_byte, rx_byte;

    assign cfg = '{len_code: data_bits, par_en: parity_en, par_odd: parity_odd,
                   stop_two: stop_two};

    assign want     = loop_sel[1] ? LB_LOCAL : (loop_sel[0] ? LB_REMOTE : LB_NORMAL);
    assign rx_line  = (r_q.mode == LB_LOCAL) ? tx_line : r_q.rx_s2;
    assign txd      = (r_q.mode == LB_LOCAL) ? 1'b1 : tx_line;
    assign tx_busy  = tx_busy_w;
    assign rx_avail = !fifo_empty;
    assign par_err  = r_q.perr;
    assign frm_err  = r_q.ferr;
    assign ovr_err  = r_q.oerr;

    always_comb begin
        r_d       = r_q;
        fifo_push = 1'b0;
        echo_take = (r_q.mode == LB_REMOTE) && r_q.echo_full && !tx_busy_w;
        tx_load   = (r_q.mode == LB_REMOTE) ? r_q.echo_full : wr_en;
        tx_byte   = (r_q.mode == LB_REMOTE) ? r_q.echo_data : wr_data;
        r_d.rx_s1 = rxd;
        r_d.rx_s2 = r_q.rx_s1;
        if (clr_status) begin
            r_d.perr = 1'b0;
            r_d.ferr = 1'b0;
            r_d.oerr = 1'b0;
        end
        if (echo_take) r_d.echo_full = 1'b0;
        if (rx_done) begin
            if (rx_perr) r_d.perr = 1'b1;
            if (rx_ferr) r_d.ferr = 1'b1;
            if (r_q.mode == LB_REMOTE) begin
                if (r_q.echo_full && !echo_take) begin
                    r_d.oerr = 1'b1;
                end else begin
                    r_d.echo_full = 1'b1;
                    r_d.echo_data = rx_byte;
                end
            end else begin
                fifo_push = 1'b1;
                if (fifo_full) r_d.oerr = 1'b1;
            end
        end
        if (!tx_busy_w && !rx_busy_w && !r_q.echo_full) r_d.mode = want;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{mode: LB_NORMAL, rx_s1: 1'b1, rx_s2: 1'b1, default: '0};
        else        r_q <= r_d;
    end

    uart_lb_tx #(.DIV_W(DIV_W)) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .div       (tx_div),
        .cfg       (cfg),
        .load      (tx_load),
        .load_data (tx_byte),
        .busy      (tx_busy_w),
        .line      (tx_line)
    );

    uart_lb_rx #(.DIV_W(DIV_W)) u_rx (
        .clk   (clk),
        .rst_n (rst_n),
        .div   (rx_div),
        .cfg   (cfg),
        .line  (rx_line),
        .busy  (rx_busy_w),
        .done  (rx_done),
        .data  (rx_byte),
        .perr  (rx_perr),
        .ferr  (rx_ferr)
    );

    uart_lb_fifo #(.W(8), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (fifo_push),
        .din   (rx_byte),
        .pop   (rd_en),
        .head  (rd_data),
        .full  (fifo_full),
        .empty (fifo_empty)
    );

    // R9: the active mode holds while either engine is mid-frame
    a_r9_mode_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_busy_w || rx_busy_w) |=> $stable(r_q.mode));

    // R5: error flags fall only through a clear
    a_r5_perr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (par_err && !clr_status) |=> par_err);
    a_r5_ferr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_err && !clr_status) |=> frm_err);

    // R11: an empty queue stays empty while echoing
    a_r11_queue_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.mode == LB_REMOTE && !rx_avail) |=> !rx_avail);

    // R12: completion against an occupied echo register raises overrun
    a_r12_overrun: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.mode == LB_REMOTE && rx_done && r_q.echo_full && tx_busy_w) |=> ovr_err);

endmodule

// File: tb/sim_uart_lb_ctrl.sv
`timescale 1ns/1ps
module sim_uart_lb_ctrl;
    localparam int BIT = 32;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic        rst_n, wr_en, rd_en, clr_status, parity_en, parity_odd, stop_two, rxd;
    logic [1:0]  loop_sel, data_bits;
    logic [15:0] tx_div, rx_div;
    logic [7:0]  wr_data, rd_data;
    logic        tx_busy, rx_avail, par_err, frm_err, ovr_err, txd;

    int checks = 0, failures = 0;
    bit fin = 1'b0;

    uart_lb_ctrl u0 (.clk(clk), .rst_n(rst_n), .loop_sel(loop_sel), .data_bits(data_bits),
        .parity_en(parity_en), .parity_odd(parity_odd), .stop_two(stop_two),
        .tx_div(tx_div), .rx_div(rx_div), .wr_en(wr_en), .wr_data(wr_data),
        .tx_busy(tx_busy), .rd_en(rd_en), .rd_data(rd_data), .rx_avail(rx_avail),
        .clr_status(clr_status), .par_err(par_err), .frm_err(frm_err), .ovr_err(ovr_err),
        .txd(txd), .rxd(rxd));

    typedef struct packed {
        logic       lcl;
        logic [1:0] nb;
        logic       pen;
        logic       podd;
        logic       bpar;
        logic       bstop;
        logic [7:0] din;
        logic [7:0] dexp;
        logic       eperr;
        logic       eferr;
    } vec_t;

    localparam vec_t VECS [7] = '{
        '{1'b0, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 8'hA5, 8'hA5, 1'b0, 1'b0},
        '{1'b0, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 8'h3F, 8'h1F, 1'b0, 1'b0},
        '{1'b0, 2'd2, 1'b1, 1'b1, 1'b0, 1'b0, 8'h55, 8'h55, 1'b0, 1'b0},
        '{1'b0, 2'd3, 1'b1, 1'b0, 1'b1, 1'b0, 8'h81, 8'h81, 1'b1, 1'b0},
        '{1'b0, 2'd3, 1'b0, 1'b0, 1'b0, 1'b1, 8'h7E, 8'h7E, 1'b0, 1'b1},
        '{1'b1, 2'd3, 1'b1, 1'b1, 1'b0, 1'b0, 8'hC3, 8'hC3, 1'b0, 1'b0},
        '{1'b1, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h2A, 8'h2A, 1'b0, 1'b0}
    };

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic clks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_frame(input logic [7:0] d, input int nb, input bit pen, input bit podd,
                              input bit bpar, input bit bstop, input int bt);
        logic p;
        p = podd ^ bpar;
        rxd = 1'b0; clks(bt);
        for (int b = 0; b < nb; b++) begin
            rxd = d[b]; p = p ^ d[b]; clks(bt);
        end
        if (pen) begin rxd = p; clks(bt); end
        if (bstop) begin rxd = 1'b0; clks(bt/2 + 4); rxd = 1'b1; clks(bt/2 - 4); end
        else begin rxd = 1'b1; clks(bt); end
        rxd = 1'b1;
    endtask

    task automatic get_frame(input int bt, input int nb, input bit pen, input int tmo,
                             output bit found, output logic [7:0] d, output bit pb,
                             output bit stp);
        found = 1'b0; d = '0; pb = 1'b0; stp = 1'b0;
        for (int i = 0; i < tmo; i++) begin
            @(negedge clk);
            if (txd == 1'b0) begin found = 1'b1; break; end
        end
        if (!found) return;
        clks(bt/2);
        for (int b = 0; b < nb; b++) begin clks(bt); d[b] = txd; end
        if (pen) begin clks(bt); pb = txd; end
        clks(bt); stp = txd;
    endtask

    task automatic host_write(input logic [7:0] d);
        @(negedge clk); wr_en = 1'b1; wr_data = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic pop();
        @(negedge clk); rd_en = 1'b1;
        @(negedge clk); rd_en = 1'b0;
    endtask

    task automatic clear();
        @(negedge clk); clr_status = 1'b1;
        @(negedge clk); clr_status = 1'b0;
    endtask

    task automatic set_cfg(input logic [1:0] nb, input bit pen, input bit podd, input bit st2);
        @(negedge clk);
        data_bits = nb; parity_en = pen; parity_odd = podd; stop_two = st2;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!fin) begin
            checks++; failures++;
            $display("FAIL watchdog expired act=0 exp=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        bit f, pb, st, f2, f3, low_seen;
        logic [7:0] d, d2;
        rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; clr_status = 1'b0; rxd = 1'b1;
        loop_sel = 2'b00; data_bits = 2'd3; parity_en = 1'b0; parity_odd = 1'b0;
        stop_two = 1'b0; tx_div = 16'd1; rx_div = 16'd1; wr_data = '0;
        clks(5); rst_n = 1'b1; clks(3);

        // R1 reset state
        chk(txd == 1'b1 && tx_busy == 1'b0, "R1 txd/tx_busy after reset", {txd, tx_busy}, 2'b10);
        chk(rx_avail == 1'b0, "R1 rx_avail after reset", rx_avail, 0);
        chk({par_err, frm_err, ovr_err} == 3'b000, "R1 flags after reset",
            {par_err, frm_err, ovr_err}, 0);

        // Vector table: R3 and R5 via rxd, R6 via internal loop
        foreach (VECS[i]) begin
            vec_t v;
            v = VECS[i];
            set_cfg(v.nb, v.pen, v.podd, 1'b0);
            clear();
            if (v.lcl) begin
                loop_sel = 2'b10; clks(4);
                low_seen = 1'b0;
                host_write(v.din);
                for (int k = 0; k < 400; k++) begin
                    @(negedge clk);
                    if (txd == 1'b0) low_seen = 1'b1;
                end
                chk(!low_seen, $sformatf("R6 vec%0d txd held at mark", i), low_seen, 0);
            end else begin
                @(negedge clk);
                send_frame(v.din, 5 + int'(v.nb), v.pen, v.podd, v.bpar, v.bstop, BIT);
                clks(40);
            end
            chk(rx_avail == 1'b1, $sformatf("R3 vec%0d rx_avail", i), rx_avail, 1);
            chk(rd_data == v.dexp, $sformatf("R3 vec%0d rd_data", i), rd_data, v.dexp);
            chk(par_err == v.eperr, $sformatf("R5 vec%0d par_err", i), par_err, v.eperr);
            chk(frm_err == v.eferr, $sformatf("R5 vec%0d frm_err", i), frm_err, v.eferr);
            pop();
            loop_sel = 2'b00; clks(4);
            chk(rx_avail == 1'b0, $sformatf("R3 vec%0d queue drained", i), rx_avail, 0);
        end

        // R2 transmit framing, even parity, two stop bits
        set_cfg(2'd3, 1'b1, 1'b0, 1'b1);
        fork
            host_write(8'h97);
            get_frame(BIT, 8, 1'b1, 100, f, d, pb, st);
        join
        chk(f && d == 8'h97, "R2 transmitted data", d, 8'h97);
        chk(pb == 1'b1, "R2 even parity bit", pb, 1);
        chk(st == 1'b1, "R2 first stop bit", st, 1);
        clks(BIT);
        chk(txd == 1'b1 && tx_busy == 1'b1, "R2 second stop bit", {txd, tx_busy}, 2'b11);
        clks(BIT);
        chk(tx_busy == 1'b0, "R2 frame finished", tx_busy, 0);

        // R4 short glitch on rxd
        set_cfg(2'd3, 1'b0, 1'b0, 1'b0);
        clear();
        rxd = 1'b0; clks(8); rxd = 1'b1; clks(400);
        chk(rx_avail == 1'b0 && frm_err == 1'b0, "R4 glitch rejected", {rx_avail, frm_err}, 0);

        // R5 sticky across a good character, then cleared
        set_cfg(2'd3, 1'b1, 1'b0, 1'b0);
        send_frame(8'h12, 8, 1'b1, 1'b0, 1'b1, 1'b0, BIT);
        send_frame(8'h34, 8, 1'b1, 1'b0, 1'b0, 1'b0, BIT);
        clks(40);
        chk(par_err == 1'b1, "R5 par_err held after good char", par_err, 1);
        pop(); pop();
        clear(); clks(2);
        chk(par_err == 1'b0, "R5 par_err cleared", par_err, 0);

        // R7 internal loop ignores rxd
        set_cfg(2'd3, 1'b0, 1'b0, 1'b0);
        loop_sel = 2'b10; clks(4);
        send_frame(8'h00, 8, 1'b0, 1'b0, 1'b0, 1'b0, BIT);
        clks(40);
        chk(rx_avail == 1'b0 && {par_err, frm_err} == 2'b00, "R7 rxd ignored",
            {rx_avail, par_err, frm_err}, 0);

        // R8 both bits set -> internal loop
        loop_sel = 2'b11; clks(4);
        low_seen = 1'b0;
        host_write(8'h5A);
        for (int k = 0; k < 400; k++) begin
            @(negedge clk);
            if (txd == 1'b0) low_seen = 1'b1;
        end
        chk(!low_seen && rx_avail && rd_data == 8'h5A, "R8 local priority",
            {low_seen, rx_avail, rd_data}, {2'b01, 8'h5A});
        pop();
        loop_sel = 2'b00; clks(4);

        // R9 mode change deferred until idle
        host_write(8'h00);
        clks(BIT * 3);
        loop_sel = 2'b10;
        clks(BIT * 2);
        chk(txd == 1'b0, "R9 running frame continues on txd", txd, 0);
        while (tx_busy) @(negedge clk);
        clks(5);
        low_seen = 1'b0;
        host_write(8'h6B);
        for (int k = 0; k < 400; k++) begin
            @(negedge clk);
            if (txd == 1'b0) low_seen = 1'b1;
        end
        chk(!low_seen && rx_avail && rd_data == 8'h6B, "R9 new mode after idle",
            {low_seen, rx_avail, rd_data}, {2'b01, 8'h6B});
        pop();
        chk(rx_avail == 1'b0, "R9 only one char looped", rx_avail, 0);
        loop_sel = 2'b00; clks(4);

        // R10 echo after full reception, odd parity
        set_cfg(2'd3, 1'b1, 1'b1, 1'b0);
        loop_sel = 2'b01; clks(4);
        fork
            send_frame(8'h3C, 8, 1'b1, 1'b1, 1'b0, 1'b0, BIT);
            begin
                clks(BIT * 9 - 8);
                chk(txd == 1'b1, "R10 no echo before char complete", txd, 1);
                get_frame(BIT, 8, 1'b1, 600, f, d, pb, st);
            end
        join
        chk(f && d == 8'h3C, "R10 echoed data", d, 8'h3C);
        chk(pb == 1'b1 && st == 1'b1, "R10 echo parity/stop", {pb, st}, 2'b11);
        chk(rx_avail == 1'b0, "R11 echo not queued", rx_avail, 0);
        clks(BIT);
        low_seen = 1'b0;
        host_write(8'h00);
        for (int k = 0; k < 400; k++) begin
            @(negedge clk);
            if (txd == 1'b0) low_seen = 1'b1;
        end
        chk(!low_seen, "R11 host write ignored in echo", low_seen, 0);

        // R12 overrun with a slower transmit rate
        set_cfg(2'd3, 1'b0, 1'b0, 1'b0);
        @(negedge clk); tx_div = 16'd5;
        clear();
        fork
            begin
                send_frame(8'h11, 8, 1'b0, 1'b0, 1'b0, 1'b0, BIT);
                send_frame(8'h22, 8, 1'b0, 1'b0, 1'b0, 1'b0, BIT);
                send_frame(8'h33, 8, 1'b0, 1'b0, 1'b0, 1'b0, BIT);
            end
            begin
                get_frame(BIT * 3, 8, 1'b0, 2000, f, d, pb, st);
                get_frame(BIT * 3, 8, 1'b0, 2000, f2, d2, pb, st);
                get_frame(BIT * 3, 8, 1'b0, 1500, f3, d, pb, st);
            end
        join
        chk(f && f2 && d2 == 8'h22, "R12 first two chars echoed", {f, f2, d2}, {2'b11, 8'h22});
        chk(!f3, "R12 third char discarded", f3, 0);
        chk(ovr_err == 1'b1, "R12 ovr_err set", ovr_err, 1);
        chk(rx_avail == 1'b0, "R11 queue empty after overrun", rx_avail, 0);

        loop_sel = 2'b00; tx_div = 16'd1; clks(20);
        fin = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule